// File: doc/BRIEF.md
# Packed Vector Bit-Insert Unit

This unit merges two 128-bit vectors element by element. For every element of the selected size, a run of bits is taken from the source vector and the remaining bits are kept from the old destination vector. The run is anchored either at the top of the element (left insert) or at the bottom (right insert). Its length is one more than the immediate, reduced modulo the element width. Every element in the vector is processed in the same cycle, and no element affects another. A pipeline stage that holds the merged vector sits between the operands and the result.

Operands arrive on a valid/ready stream, and the result leaves on a second valid/ready stream. An input beat is taken on a clock edge where `in_valid` and `in_ready` are both high. Its result is presented on the next cycle. The output register holds at most one result, so `in_ready` is high whenever that register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the result must stay frozen and no new operands are taken. The source keeps `in_valid` and its operands steady until the beat is accepted.

Top module: `vec_bitins_unit`

## Requirements
- R1: The insert length is L = (in_imm mod W) + 1, where W is the element width and in_imm is a 6-bit unsigned value. Only the low log2(W) bits of in_imm affect the result.
- R2: With in_left = 1, the top L bits of each result element come from the same element of in_src, and the other W-L low bits come from in_dst.
- R3: With in_left = 0, the bottom L bits of each result element come from in_src, and the other W-L high bits come from in_dst.
- R4: When L equals W, each result element equals its source element, whatever in_dst holds.
- R5: in_size selects the element width: 0 for 8 bits, 1 for 16 bits, 2 for 32 bits and 3 for 64 bits. Each element is formed from its own bit range only, and all elements are formed in parallel.
- R6: An input accepted on a clock edge (in_valid and in_ready both high) makes out_valid high with the merged result on out_data after that same edge.
- R7: in_ready equals (!out_valid || out_ready). While out_valid is high and out_ready is low, out_valid and out_data hold steady.
- R8: A synchronous active-high reset clears out_valid and out_data to zero.
- R9: When a result is consumed and no input is accepted on that edge, out_valid goes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand beat valid |
| in_ready | output | 1 | Unit can take an operand beat |
| in_src | input | 128 | Source vector, supplies the inserted bits |
| in_dst | input | 128 | Old destination vector, supplies the kept bits |
| in_size | input | 2 | Element size code (0=8, 1=16, 2=32, 3=64 bits) |
| in_left | input | 1 | 1 = insert at the top of each element, 0 = at the bottom |
| in_imm | input | 6 | Immediate; insert length is (imm mod W)+1 |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream accepts the result |
| out_data | output | 128 | Merged result vector |

## Verification
An error in the mask generator shows up as wrong bits in out_data in the cycle right after the beat is accepted. The wrong bits are confined to element edges or to the split point that the immediate selects. For that reason, the vectors use a contrasting source and destination, and they place the split next to both ends of an element. A fault in the output register shows up as a lost or changed result while back-pressure is applied, or as a valid flag that stays high or never rises. These faults can be seen within one or two cycles of a stalled or drained transfer.

// File: rtl/vec_bitins_pkg.sv
package vec_bitins_pkg;
  localparam int VEC_W     = 128;
  localparam int IMM_W     = 6;   // wide enough for 64-bit elements
  localparam int SIZE_W    = 2;
  localparam int NUM_SIZES = 1 << SIZE_W;
  localparam int MIN_ELEM  = 8;

  typedef enum logic [SIZE_W-1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } elem_size_e;
endpackage

// File: rtl/vec_bitins_mask.sv
module vec_bitins_mask
  import vec_bitins_pkg::*;
#(
  parameter int VW = VEC_W,
  parameter int IW = IMM_W
) (
  input  logic [SIZE_W-1:0] size,
  input  logic              left,
  input  logic [IW-1:0]     imm,
  output logic [VW-1:0]     mask
);
  logic [VW-1:0] per_size [NUM_SIZES];

  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    localparam int W = MIN_ELEM << s;
    logic [IW-1:0] k;
    // bit index inside the element that is the last one taken from the source
    assign k = imm & IW'(W - 1);
    for (genvar j = 0; j < VW; j++) begin : g_bit
      localparam int IDX = j % W;
      // a bit belongs to the run if it lies within k of the anchor edge;
      // the comparison never reaches across an element boundary
      assign per_size[s][j] = left ? ((IDX + int'(k)) >= (W - 1))
                                   : (int'(k) >= IDX);
    end
  end

  assign mask = per_size[size];
endmodule

// File: rtl/vec_bitins_stage.sv
module vec_bitins_stage #(
  parameter int DW = 128
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_data  <= in_data;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  p_accept_gives_valid_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));

  p_stall_holds_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_drain_drops_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));
endmodule

// File: rtl/vec_bitins_unit.sv
module vec_bitins_unit
  import vec_bitins_pkg::*;
#(
  parameter int VW = VEC_W,
  parameter int IW = IMM_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [VW-1:0]     in_src,
  input  logic [VW-1:0]     in_dst,
  input  logic [SIZE_W-1:0] in_size,
  input  logic              in_left,
  input  logic [IW-1:0]     in_imm,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [VW-1:0]     out_data
);
  logic [VW-1:0] mask;
  logic [VW-1:0] merged;

  vec_bitins_mask #(.VW(VW), .IW(IW)) u_mask (
    .size (in_size),
    .left (in_left),
    .imm  (in_imm),
    .mask (mask)
  );

  assign merged = (in_src & mask) | (in_dst & ~mask);

  vec_bitins_stage #(.DW(VW)) u_stage (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (merged),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  // R1: the run is never empty; in right mode bit 0 of every 64-bit lane is taken
  p_run_nonempty_r1: assert property (@(posedge clk) disable iff (rst)
    (!in_left && in_size == SZ_DBL) |-> (mask[0] && mask[64]));

  // R4: identical source and destination always give back the source
  p_same_operands_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_src == in_dst) |=> (out_data == $past(in_src)));
endmodule

// File: tb/vec_bitins_unit_bench.sv
module vec_bitins_unit_bench;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid, in_ready, in_left, out_valid, out_ready;
  logic [127:0] in_src, in_dst, out_data;
  logic [1:0]   in_size;
  logic [5:0]   in_imm;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vec_bitins_unit u_vec_bitins_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_src(in_src), .in_dst(in_dst), .in_size(in_size), .in_left(in_left),
    .in_imm(in_imm), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data)
  );

  typedef struct packed {
    logic [127:0] src;
    logic [127:0] dst;
    logic [1:0]   size;
    logic         left;
    logic [5:0]   imm;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{128'h0123456789abcdef_fedcba9876543210, 128'h55aa55aa_33cc33cc_0f0f0f0f_f0f0f0f0, 2'd0, 1'b1, 6'd0},
    '{128'h0123456789abcdef_fedcba9876543210, 128'h55aa55aa_33cc33cc_0f0f0f0f_f0f0f0f0, 2'd0, 1'b0, 6'd6},
    '{128'hdeadbeef_cafef00d_12345678_9abcdef0, 128'h0, 2'd1, 1'b1, 6'd9},
    '{128'hdeadbeef_cafef00d_12345678_9abcdef0, {128{1'b1}}, 2'd1, 1'b0, 6'd31},
    '{128'hffff0000_ffff0000_0000ffff_0000ffff, 128'h12345678_9abcdef0_0fedcba9_87654321, 2'd2, 1'b1, 6'd17},
    '{128'hffff0000_ffff0000_0000ffff_0000ffff, 128'h12345678_9abcdef0_0fedcba9_87654321, 2'd2, 1'b0, 6'd40},
    '{128'h8000000000000001_7ffffffffffffffe, 128'h0123456789abcdef_0123456789abcdef, 2'd3, 1'b1, 6'd62},
    '{128'h8000000000000001_7ffffffffffffffe, 128'h0123456789abcdef_0123456789abcdef, 2'd3, 1'b0, 6'd0},
    '{128'ha5a5a5a5_a5a5a5a5_a5a5a5a5_a5a5a5a5, 128'h5a5a5a5a_5a5a5a5a_5a5a5a5a_5a5a5a5a, 2'd3, 1'b1, 6'd31},
    '{128'hfedcba98_76543210_fedcba98_76543210, 128'h0, 2'd0, 1'b0, 6'd7}
  };

  function automatic logic [127:0] model(logic [127:0] s, logic [127:0] d,
                                         logic [1:0] size, logic left, logic [5:0] imm);
    int w = 8 << size;
    int len = (int'(imm) % w) + 1;
    logic [63:0] emask = (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 1);
    logic [63:0] keep, se, de, re;
    logic [127:0] res = '0;
    // keep = bits taken from the destination
    if (len == w) keep = '0;
    else if (left) keep = (64'd1 << (w - len)) - 1;
    else keep = emask & ~((64'd1 << len) - 1);
    for (int e = 0; e < 128 / w; e++) begin
      se = 64'(s >> (e * w)) & emask;
      de = 64'(d >> (e * w)) & emask;
      re = (se & ~keep) | (de & keep);
      res = res | (128'(re) << (e * w));
    end
    return res;
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(logic [127:0] s, logic [127:0] d, logic [1:0] sz, logic l, logic [5:0] im);
    @(negedge clk);
    in_valid = 1'b1; in_src = s; in_dst = d; in_size = sz; in_left = l; in_imm = im;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    rst = 1'b1; in_valid = 0; out_ready = 1; in_src = '0; in_dst = '0;
    in_size = 0; in_left = 0; in_imm = 0;
    repeat (3) @(negedge clk);
    check("R8 valid after reset", 128'(out_valid), 128'd0);
    check("R8 data after reset", out_data, 128'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      send(VECS[i].src, VECS[i].dst, VECS[i].size, VECS[i].left, VECS[i].imm);
      check("R6 valid", 128'(out_valid), 128'd1);
      check("R2 R3 R5 vector", out_data,
            model(VECS[i].src, VECS[i].dst, VECS[i].size, VECS[i].left, VECS[i].imm));
    end

    // hand-computed values
    send({128{1'b1}}, '0, 2'd0, 1'b1, 6'd2);
    check("R2 byte left len3", out_data, {16{8'he0}});
    send({128{1'b1}}, '0, 2'd0, 1'b0, 6'd2);
    check("R3 byte right len3", out_data, {16{8'h07}});
    send({128{1'b1}}, '0, 2'd0, 1'b0, 6'd10);
    check("R1 imm mod width", out_data, {16{8'h07}});
    send(128'h0123456789abcdef_fedcba9876543210, {128{1'b1}}, 2'd3, 1'b0, 6'd63);
    check("R4 full length dbl", out_data, 128'h0123456789abcdef_fedcba9876543210);
    send(128'h00ff00ff_00ff00ff_00ff00ff_00ff00ff, 128'h12345678_12345678_12345678_12345678, 2'd1, 1'b1, 6'd15);
    check("R4 full length half", out_data, 128'h00ff00ff_00ff00ff_00ff00ff_00ff00ff);
    send(128'h1, '0, 2'd2, 1'b0, 6'd0);
    check("R5 word lanes isolated", out_data, 128'h1);

    @(negedge clk);
    check("R9 valid drops", 128'(out_valid), 128'd0);

    // back-pressure
    out_ready = 1'b0;
    send({128{1'b1}}, '0, 2'd0, 1'b0, 6'd0);
    check("R6 stalled result", out_data, {16{8'h01}});
    check("R7 ready low", 128'(in_ready), 128'd0);
    in_valid = 1'b1; in_src = '0; in_dst = {128{1'b1}}; in_size = 0; in_left = 0; in_imm = 0;
    repeat (2) @(negedge clk);
    check("R7 hold data", out_data, {16{8'h01}});
    check("R7 hold valid", 128'(out_valid), 128'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 next beat", out_data, {16{8'hfe}});

    // reset during activity
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R8 mid reset valid", 128'(out_valid), 128'd0);
    check("R8 mid reset data", out_data, 128'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule